// File: doc/BRIEF.md
# Conditional Performance Counter Unit

The block holds a small bank of event counters, four by default, 32 bits wide. Each channel picks one single-cycle strobe from a CPU event bus, or picks none. Typical sources are cycles, branches, retired instructions, cache misses and stalls. One shared counting window decides when the enabled channels may count.

Three window modes exist. In run mode the window opens on a program-start marker and closes on a break. In the two conditional modes the window spans the interval between two break-condition markers, in either order.

Branch events advance their counter by two per strobe. A counter that wraps sticks at all ones and raises a sticky overflow flag. Counting follows a CPU clock-enable, so it freezes while the CPU clock is halted in sleep.

Software-side readback uses a channel index. An initialize strobe wipes the whole bank. A per-channel clear wipes one counter. A configuration-error output warns when a conditional mode is selected with every channel disabled.

Top module: `perf_count_unit`

## Requirements
- R1: After reset every counter reads 0, every overflow flag reads 0 and the counting window is closed.
- R2: With mode_i = 0 (run), a cycle with run_start_i high opens the window and a cycle with brk_i high closes it. A channel counts events in the cycles after the opening cycle, up to and including the closing cycle. In this mode cond1_i and cond2_i have no effect.
- R3: With mode_i = 1, cond1_i opens the window and cond2_i closes it. With mode_i = 2, cond2_i opens and cond1_i closes. With mode_i = 3 the window never opens. In modes 1, 2 and 3, run_start_i and brk_i have no effect, and a closing marker seen while the window is closed is ignored.
- R4: An opening marker that arrives while the window is already open is ignored: the window stays open and no counter restarts.
- R5: A channel whose select field is 0 never counts. A select value s from 1 to NEVT counts strobes on evt_i[s-1]. Channel c's select field is sel_i[c*SELW +: SELW], and the channels count independently in the same cycle.
- R6: Select value 2 is the branch event: each strobe adds 2 to the counter. Every other event adds 1.
- R7: When an addition would exceed 2^WIDTH-1, the counter becomes 2^WIDTH-1 and its overflow flag sets. Both then hold until that channel is cleared or initialized.
- R8: While clk_en_i is low, no counter changes, and the window ignores every marker. Clear and initialize still act.
- R9: clr_i[c] high in a cycle zeroes channel c's counter and overflow flag at the next edge. It wins over an increment in the same cycle and leaves the other channels untouched.
- R10: init_i high zeroes every counter and overflow flag and closes the window at the next edge.
- R11: cfg_err_o is high, in the same cycle and without a clock edge, exactly when mode_i is 1 or 2 and every select field is 0.
- R12: rd_cnt_o and rd_ovf_o show, combinationally, the counter and overflow flag of the channel numbered rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | CPU clock running; low while halted in sleep |
| init_i | input | 1 | Clear all counters and close the window |
| mode_i | input | 2 | Window mode: 0 run, 1 cond1 to cond2, 2 cond2 to cond1, 3 off |
| run_start_i | input | 1 | Program execution start marker |
| brk_i | input | 1 | Break marker |
| cond1_i | input | 1 | Break condition 1 satisfied |
| cond2_i | input | 1 | Break condition 2 satisfied |
| evt_i | input | NEVT | Event strobes from the CPU |
| sel_i | input | NCH*SELW | Per-channel event select, 0 disables the channel |
| clr_i | input | NCH | Per-channel clear |
| rd_idx_i | input | IDXW | Channel chosen for readback |
| rd_cnt_o | output | WIDTH | Count of the chosen channel |
| rd_ovf_o | output | 1 | Overflow flag of the chosen channel |
| cfg_err_o | output | 1 | Conditional mode selected with every channel disabled |

## Verification
Two pairs of functions can land on the same cycle.

The first pair is a channel clear and a qualifying event strobe on that channel. The bench asserts clear together with all-ones strobes inside an open window. It expects zero on that channel while its neighbours keep counting.

The second pair is a closing marker and an event. The bench pulses brk_i, or the conditional closing marker, with strobes set. It expects that cycle's events to be included, while events on the opening cycle are excluded.

The bench builds expected values from an arithmetic model of these rules. It uses an 8-bit instance, so saturation and overflow are reached within the sweeps.

// File: rtl/perf_pkg.sv
package perf_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_C1C2 = 2'd1,
        MODE_C2C1 = 2'd2,
        MODE_OFF  = 2'd3
    } perf_mode_e;

    // select value whose events advance the count by two
    localparam int unsigned BRANCH_SEL = 2;
endpackage

// File: rtl/perf_window.sv
module perf_window
    import perf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en_i,
    input  logic       init_i,
    input  logic [1:0] mode_i,
    input  logic       run_start_i,
    input  logic       brk_i,
    input  logic       cond1_i,
    input  logic       cond2_i,
    output logic       open_o
);
    typedef struct packed {
        logic open;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    opener, closer;

    always_comb begin
        opener = 1'b0;
        closer = 1'b0;
        case (perf_mode_e'(mode_i))
            MODE_RUN:  begin opener = run_start_i; closer = brk_i;   end
            MODE_C1C2: begin opener = cond1_i;     closer = cond2_i; end
            MODE_C2C1: begin opener = cond2_i;     closer = cond1_i; end
            default:   begin opener = 1'b0;        closer = 1'b0;    end
        endcase

        st_d = st_q;
        if (init_i) begin
            st_d.open = 1'b0;
        end else if (clk_en_i) begin
            if (st_q.open) begin
                if (closer) st_d.open = 1'b0;
            end else if (opener) begin
                st_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;

    // an open window survives a repeated opener
    assert_reopen_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && st_q.open && !closer) |=> st_q.open);

    // a stalled clock freezes the window
    assert_window_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !clk_en_i) |=> $stable(st_q.open));

    // initialize closes the window
    assert_init_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !st_q.open);

    // off mode never opens
    assert_off_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && mode_i == 2'd3) |=> !st_q.open);
endmodule

// File: rtl/perf_channel.sv
module perf_channel #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned NEVT  = 7,
    parameter int unsigned SELW  = 3,
    parameter int unsigned BR    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_i,
    input  logic             win_i,
    input  logic             clr_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic [NEVT-1:0]  evt_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             ovf;
    } ch_st_t;

    ch_st_t         st_d, st_q;
    logic           hit;
    logic [1:0]     step;
    logic [WIDTH:0] sum;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NEVT; k++) begin
            if (sel_i == SELW'(k + 1)) hit = evt_i[k];
        end
        step = (sel_i == SELW'(BR)) ? 2'd2 : 2'd1;
        sum  = {1'b0, st_q.cnt} + (WIDTH+1)'(step);

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (clk_en_i && win_i && hit && !st_q.ovf) begin
            if (sum[WIDTH]) begin
                st_d.cnt = ALL_ONES;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = sum[WIDTH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0 && !st_q.ovf));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr_i) |=> (st_q.ovf && st_q.cnt == ALL_ONES));

    assert_ovf_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> st_q.cnt == ALL_ONES);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_i && !clr_i) |=> $stable(st_q));

    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !st_q.ovf) |=> (st_q.ovf || (st_q.cnt - $past(st_q.cnt)) <= WIDTH'(2)));

    assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && sel_i == '0) |=> $stable(st_q));
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
    import perf_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned NEVT  = 7,
    parameter int unsigned SELW  = $clog2(NEVT + 1),
    parameter int unsigned IDXW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_i,
    input  logic              init_i,
    input  logic [1:0]        mode_i,
    input  logic              run_start_i,
    input  logic              brk_i,
    input  logic              cond1_i,
    input  logic              cond2_i,
    input  logic [NEVT-1:0]   evt_i,
    input  logic [NCH*SELW-1:0] sel_i,
    input  logic [NCH-1:0]    clr_i,
    input  logic [IDXW-1:0]   rd_idx_i,
    output logic [WIDTH-1:0]  rd_cnt_o,
    output logic              rd_ovf_o,
    output logic              cfg_err_o
);
    logic             win;
    logic [WIDTH-1:0] cnt [NCH];
    logic [NCH-1:0]   ovf;
    logic             any_sel;

    perf_window u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_i    (clk_en_i),
        .init_i      (init_i),
        .mode_i      (mode_i),
        .run_start_i (run_start_i),
        .brk_i       (brk_i),
        .cond1_i     (cond1_i),
        .cond2_i     (cond2_i),
        .open_o      (win)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        perf_channel #(
            .WIDTH (WIDTH),
            .NEVT  (NEVT),
            .SELW  (SELW),
            .BR    (BRANCH_SEL)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clk_en_i (clk_en_i),
            .win_i    (win),
            .clr_i    (clr_i[c] | init_i),
            .sel_i    (sel_i[c*SELW +: SELW]),
            .evt_i    (evt_i),
            .cnt_o    (cnt[c]),
            .ovf_o    (ovf[c])
        );
    end

    always_comb begin
        any_sel = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (sel_i[c*SELW +: SELW] != '0) any_sel = 1'b1;
        end
        cfg_err_o = ((mode_i == MODE_C1C2) || (mode_i == MODE_C2C1)) && !any_sel;
    end

    always_comb begin
        rd_cnt_o = '0;
        rd_ovf_o = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_idx_i == IDXW'(c)) begin
                rd_cnt_o = cnt[c];
                rd_ovf_o = ovf[c];
            end
        end
    end

    // a closed window keeps every counter still
    assert_closed_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && clr_i == '0 && !init_i) |=> $stable(rd_cnt_o) || $changed(rd_idx_i));
endmodule

// File: tb/perf_count_unit_tb.sv
`timescale 1ns/100ps
module perf_count_unit_tb_top;
    localparam int NCH = 4, W = 8, NEVT = 7, SELW = 3;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic clk_en_i = 1'b0, init_i = 1'b0, run_start_i = 1'b0, brk_i = 1'b0;
    logic cond1_i = 1'b0, cond2_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [NEVT-1:0] evt_i = '0;
    logic [NCH*SELW-1:0] sel_i;
    logic [NCH-1:0] clr_i = '0;
    logic [1:0] rd_idx_i = '0;
    logic [W-1:0] rd_cnt_o;
    logic rd_ovf_o, cfg_err_o;

    logic [SELW-1:0] sel [NCH];
    int  exp_cnt [NCH];
    bit  exp_ovf [NCH];
    bit  exp_win;
    int  n_chk = 0, n_bad = 0;
    logic [6:0] lfsr = 7'h5A;

    always #2 clk = ~clk;

    always_comb for (int c = 0; c < NCH; c++) sel_i[c*SELW +: SELW] = sel[c];

    perf_count_unit #(.NCH(NCH), .WIDTH(W), .NEVT(NEVT)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en_i), .init_i(init_i),
        .mode_i(mode_i), .run_start_i(run_start_i), .brk_i(brk_i),
        .cond1_i(cond1_i), .cond2_i(cond2_i), .evt_i(evt_i), .sel_i(sel_i),
        .clr_i(clr_i), .rd_idx_i(rd_idx_i), .rd_cnt_o(rd_cnt_o),
        .rd_ovf_o(rd_ovf_o), .cfg_err_o(cfg_err_o));

    task automatic step(input logic st, bk, c1, c2, input logic [6:0] ev,
                        input logic en, input logic [3:0] clr, input logic ini);
        bit opn, cls;
        run_start_i = st; brk_i = bk; cond1_i = c1; cond2_i = c2;
        evt_i = ev; clk_en_i = en; clr_i = clr; init_i = ini;
        for (int c = 0; c < NCH; c++) begin
            int inc;
            inc = 0;
            if (sel[c] != 0 && sel[c] <= NEVT && ev[sel[c]-1] && exp_win && en)
                inc = (sel[c] == 2) ? 2 : 1;
            if (ini || clr[c]) begin
                exp_cnt[c] = 0; exp_ovf[c] = 0;
            end else if (!exp_ovf[c]) begin
                if (exp_cnt[c] + inc > MAXV) begin
                    exp_cnt[c] = MAXV; exp_ovf[c] = 1;
                end else exp_cnt[c] = exp_cnt[c] + inc;
            end
        end
        case (mode_i)
            2'd0: begin opn = st; cls = bk; end
            2'd1: begin opn = c1; cls = c2; end
            2'd2: begin opn = c2; cls = c1; end
            default: begin opn = 0; cls = 0; end
        endcase
        if (ini) exp_win = 0;
        else if (en) exp_win = exp_win ? !cls : opn;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [6:0] ev);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, ev, 1, 4'b0, 0);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            rd_idx_i = 2'(c);
            #0.3;
            n_chk++;
            if (rd_cnt_o !== W'(exp_cnt[c]) || rd_ovf_o !== exp_ovf[c]) begin
                n_bad++;
                $display("FAIL %s R12 ch%0d: cnt=%0d ovf=%0b expected cnt=%0d ovf=%0b",
                         tag, c, rd_cnt_o, rd_ovf_o, exp_cnt[c], exp_ovf[c]);
            end
        end
    endtask

    task automatic check_err(input string tag, input logic exp);
        #0.3;
        n_chk++;
        if (cfg_err_o !== exp) begin
            n_bad++;
            $display("FAIL %s: cfg_err=%0b expected %0b", tag, cfg_err_o, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: done=0 expected done=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin sel[c] = '0; exp_cnt[c] = 0; exp_ovf[c] = 0; end
        exp_win = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // run mode
        sel[0] = 1; sel[1] = 2; sel[2] = 3; sel[3] = 0; mode_i = 2'd0;
        idle(5, 7'h7F);
        step(0, 0, 1, 1, 7'h7F, 1, 4'b0, 0);
        check_all("R2 before start");
        step(1, 0, 0, 0, 7'h7F, 1, 4'b0, 0);
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
            step(0, 0, 0, 0, lfsr, (i % 3) != 2, 4'b0, 0);
        end
        check_all("R2 R5 R6 R8 open window");
        step(1, 0, 0, 0, 7'h7F, 1, 4'b0, 0);
        idle(6, 7'h07);
        check_all("R4 reopen ignored");
        step(0, 1, 0, 0, 7'h7F, 1, 4'b0, 0);
        idle(5, 7'h7F);
        check_all("R2 break closes");

        // initialize
        step(0, 0, 0, 0, 7'h7F, 1, 4'b0, 1);
        check_all("R10 init");
        idle(4, 7'h7F);
        check_all("R10 window closed");

        // exhaustive strobe sweep on upper selects
        sel[0] = 4; sel[1] = 5; sel[2] = 6; sel[3] = 7;
        step(1, 0, 0, 0, 7'h00, 1, 4'b0, 0);
        for (int i = 0; i < 128; i++) step(0, 0, 0, 0, 7'(i), 1, 4'b0, 0);
        step(0, 1, 0, 0, 7'h00, 1, 4'b0, 0);
        check_all("R5 sweep");

        // conditional modes
        step(0, 0, 0, 0, 7'h00, 1, 4'b0, 1);
        sel[0] = 1; sel[1] = 2; sel[2] = 1; sel[3] = 3;
        mode_i = 2'd1;
        step(1, 0, 0, 0, 7'h7F, 1, 4'b0, 0);
        step(0, 0, 0, 1, 7'h7F, 1, 4'b0, 0);
        idle(3, 7'h7F);
        check_all("R3 mode1 stray markers");
        step(0, 0, 1, 0, 7'h7F, 1, 4'b0, 0);
        idle(4, 7'h03);
        step(0, 0, 1, 0, 7'h7F, 1, 4'b0, 0);
        step(0, 1, 0, 0, 7'h7F, 1, 4'b0, 0);
        step(0, 0, 0, 1, 7'h7F, 1, 4'b0, 0);
        idle(3, 7'h7F);
        check_all("R3 mode1 window");
        mode_i = 2'd2;
        step(0, 0, 1, 0, 7'h7F, 1, 4'b0, 0);
        step(0, 0, 0, 1, 7'h05, 1, 4'b0, 0);
        idle(5, 7'h06);
        // stalled clock ignores a closing marker
        step(0, 0, 1, 0, 7'h7F, 0, 4'b0, 0);
        idle(2, 7'h7F);
        check_all("R8 stalled marker");
        step(0, 0, 1, 0, 7'h7F, 1, 4'b0, 0);
        idle(3, 7'h7F);
        check_all("R3 mode2 window");
        mode_i = 2'd3;
        step(1, 0, 1, 1, 7'h7F, 1, 4'b0, 0);
        idle(3, 7'h7F);
        check_all("R3 mode3 off");

        // overflow and saturation
        mode_i = 2'd0;
        step(0, 0, 0, 0, 7'h00, 1, 4'b0, 1);
        step(1, 0, 0, 0, 7'h00, 1, 4'b0, 0);
        idle(140, 7'h7F);
        check_all("R7 branch saturates");
        idle(130, 7'h7F);
        check_all("R7 sticky");

        // clear collides with increments
        step(0, 0, 0, 0, 7'h7F, 1, 4'b0010, 0);
        check_all("R9 clear wins");
        step(0, 0, 0, 0, 7'h7F, 1, 4'b1001, 0);
        idle(2, 7'h7F);
        check_all("R9 clear others");

        // configuration error
        for (int c = 0; c < NCH; c++) sel[c] = '0;
        mode_i = 2'd1; check_err("R11 mode1 none", 1'b1);
        mode_i = 2'd2; check_err("R11 mode2 none", 1'b1);
        mode_i = 2'd0; check_err("R11 run none", 1'b0);
        mode_i = 2'd3; check_err("R11 off none", 1'b0);
        mode_i = 2'd1; sel[3] = 1; check_err("R11 mode1 one", 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule